// File: doc/BRIEF.md
# Serial Channel Register Core with Read-Qualified Status Flags

This block is the register side of a single-buffered asynchronous serial channel. A byte-wide bus writes and reads six registers: frame mode, bit rate, control, transmit data, status and receive data. Received characters arrive one byte at a time from an external deserializer through a valid strobe. Outgoing characters are handed to a built-in shift engine, which turns each one into a line frame according to the decoded mode.

The status register is the core of the block. Its hardware flags can be cleared only by software that has first read them as 1 and then writes 0. A bus write never sets a flag. The transmit-empty and transmit-end flags together sequence transmission. Software writes a byte and then clears transmit-empty. The core hands the byte to the shifter as soon as the shifter is idle. At that handoff both flags rise again, so the next byte can be queued while the current frame is still on the line.

Top module: `sci_core`

## Requirements
- R1: After reset the status register reads 0x84, the serial line is high and the transmit interrupt is low.
- R2: Register addresses are 0 mode, 1 bit rate, 2 control, 3 transmit data, 4 status and 5 receive data. Control bit 7 enables the transmit interrupt, bit 5 enables transmit and bit 4 enables receive. Read data appears on the port one clock after the read strobe.
- R3: Status bits are 7 transmit-empty, 6 receive-full, 5 overrun and 2 transmit-end. Bit 0 is a plain read/write software bit and bit 1 reads 0. A status write never sets bits 7..3.
- R4: A status write clears a flag in bits 7..3 only when that bit is written 0 and was read as 1 since the previous status write. Writing 0 to a flag that was not read leaves it set.
- R5: When receive is enabled, an incoming byte sets receive-full and can be read at address 5. Reading address 5 clears receive-full.
- R6: A byte that arrives while receive-full is set is discarded, and overrun is set.
- R7: While receive is disabled, incoming bytes are ignored.
- R8: Writing transmit data clears transmit-end. Clearing transmit-empty also clears transmit-end and requests transmission. When the shifter takes the byte, transmit-empty and transmit-end are both set again.
- R9: While transmit is disabled, transmit-empty and transmit-end are held at 1.
- R10: A frame is a 0 start bit, then the data bits LSB first, then an optional parity bit, then 1 or 2 stop bits at 1. The data is 7 bits when mode bit 6 is 1 and 8 bits otherwise. Mode bit 5 enables parity, mode bit 4 selects odd (1) or even (0) parity, and mode bit 3 selects 2 stop bits.
- R11: Every bit lasts OVS × (rate + 1) × 4^n clock cycles, where n is mode bits 1..0.
- R12: A byte queued while a frame is in flight starts one cycle after that frame's last stop bit. With two stop bits, 8 data bits and no parity, the start bits of back-to-back frames are 11 bit periods plus one cycle apart.
- R13: The transmit interrupt equals the interrupt-enable control bit ANDed with transmit-empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_line | output | 1 | Serial output line |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The frame engine is driven with a table of mode, rate and data combinations. The table covers 8 and 7 data bits (with a set bit 7 that must be dropped), even and odd parity with data whose parity differs, one and two stop bits, and prescale values 0, 1 and 2. Each line bit is sampled at its middle, so a wrong bit order, a wrong parity sense or a wrong period shows up as a bad frame. The status flags are tried with write-0 both before and after a read, with writes of all ones, with a double arrival and with receive disabled. These cases tell the read-qualified clear apart from a plain write and from a set-on-write. A back-to-back transmit with two stop bits measures the spacing between start bits, which separates a one-stop from a two-stop frame length.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
package sci_pkg;
  localparam int ST_TXE  = 7;
  localparam int ST_RXF  = 6;
  localparam int ST_OVR  = 5;
  localparam int ST_TEND = 2;
  localparam int ST_SW   = 0;
  localparam int CT_TIE  = 7;
  localparam int CT_TE   = 5;
  localparam int CT_RE   = 4;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_RATE = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_TXD  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;
  localparam logic [7:0] ST_RESET = 8'h84;
  localparam int MAX_FRAME = 12;

  typedef struct packed {
    logic       seven;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic [1:0] presc;
  } frame_cfg_t;
endpackage

// File: rtl/sci_mode_dec.sv
`timescale 1ns/1ps
module sci_mode_dec
  import sci_pkg::*;
(
  input  logic [7:0]  mode_i,
  output frame_cfg_t  cfg_o
);
  logic unused_mode;
  assign unused_mode = ^{mode_i[7], mode_i[2]};

  assign cfg_o.seven   = mode_i[6];
  assign cfg_o.par_en  = mode_i[5];
  assign cfg_o.par_odd = mode_i[4];
  assign cfg_o.stop2   = mode_i[3];
  assign cfg_o.presc   = mode_i[1:0];
endmodule

// File: rtl/sci_status.sv
`timescale 1ns/1ps
module sci_status
  import sci_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_stat_i,
  input  logic       wr_stat_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_txd_i,
  input  logic       rd_rx_i,
  input  logic       rx_push_i,
  input  logic       tx_ack_i,
  input  logic       te_i,
  output logic [7:0] stat_o
);
  localparam int FLAG_LO = 3;
  localparam int FLAG_N  = 8 - FLAG_LO;

  logic [7:0]        st_q, st_d;
  logic [FLAG_N-1:0] seen_q, seen_d;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    if (rd_stat_i) seen_d = seen_q | st_q[7:FLAG_LO];
    if (wr_stat_i) begin
      for (int b = FLAG_LO; b < 8; b++) begin
        if (seen_q[b-FLAG_LO] && !wdata_i[b]) st_d[b] = 1'b0;
      end
      st_d[ST_SW] = wdata_i[ST_SW];
      seen_d      = seen_q & wdata_i[7:FLAG_LO];
      if (st_q[ST_TXE] && !st_d[ST_TXE]) st_d[ST_TEND] = 1'b0;
    end
    if (wr_txd_i) st_d[ST_TEND] = 1'b0;
    if (rd_rx_i)  st_d[ST_RXF]  = 1'b0;
    if (rx_push_i) begin
      if (st_q[ST_RXF]) st_d[ST_OVR] = 1'b1;
      else              st_d[ST_RXF] = 1'b1;
    end
    if (tx_ack_i || !te_i) begin
      st_d[ST_TXE]  = 1'b1;
      st_d[ST_TEND] = 1'b1;
    end
    st_d[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RESET;
      seen_q <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  assign stat_o = st_q;

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !te_i |=> (st_q[ST_TXE] && st_q[ST_TEND]));
  // R3
  rxf_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q[ST_RXF]) |-> $past(rx_push_i));
  // R6
  ovr_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q[ST_OVR]) |-> $past(rx_push_i && st_q[ST_RXF]));
  // R4
  ovr_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st_q[ST_OVR]) |-> $past(wr_stat_i));
  // R8
  txe_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q[ST_TXE]) |-> $past(tx_ack_i || !te_i));
endmodule

// File: rtl/sci_tx_shift.sv
`timescale 1ns/1ps
module sci_tx_shift
  import sci_pkg::*;
#(
  parameter int OVS = 32
)(
  input  logic       clk,
  input  logic       rst,
  input  frame_cfg_t cfg_i,
  input  logic [7:0] rate_i,
  input  logic [7:0] data_i,
  input  logic       req_i,
  output logic       ack_o,
  output logic       line_o
);
  localparam int CW = $clog2(OVS * 256 * 64 + 1);
  localparam int LW = $clog2(MAX_FRAME + 1);

  logic                 busy_q;
  logic [MAX_FRAME-1:0] sh_q, frm;
  logic [LW-1:0]        left_q, len;
  logic [CW-1:0]        cnt_q, per_q, per_d;
  logic                 line_q;
  int                   nb;
  logic                 par;

  always_comb begin
    nb  = cfg_i.seven ? 7 : 8;
    par = (cfg_i.seven ? ^data_i[6:0] : ^data_i) ^ cfg_i.par_odd;
    frm = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nb) frm[1+i] = data_i[i];
    end
    if (cfg_i.par_en) frm[1+nb] = par;
    len   = LW'(2 + nb) + LW'(cfg_i.par_en) + LW'(cfg_i.stop2);
    per_d = (CW'(OVS) * (CW'(rate_i) + CW'(1))) << {cfg_i.presc, 1'b0};
  end

  assign ack_o  = req_i && !busy_q;
  assign line_o = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      per_q  <= '0;
      line_q <= 1'b1;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        sh_q   <= frm;
        left_q <= len;
        per_q  <= per_d;
        cnt_q  <= per_d - CW'(1);
        line_q <= frm[0];
      end
    end else if (cnt_q == '0) begin
      if (left_q == LW'(1)) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        sh_q   <= {1'b1, sh_q[MAX_FRAME-1:1]};
        left_q <= left_q - LW'(1);
        cnt_q  <= per_q - CW'(1);
        line_q <= sh_q[1];
      end
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R10
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !line_q);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> line_q);
  // R12
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (left_q != '0 && left_q <= LW'(MAX_FRAME)));
endmodule

// File: rtl/sci_core.sv
`timescale 1ns/1ps
module sci_core
  import sci_pkg::*;
#(
  parameter int OVS = 32
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_line,
  output logic       tx_irq
);
  logic [7:0] mode_q, rate_q, ctrl_q, txd_q, rxd_q, rdata_q, stat;
  logic       wr_stat, rd_stat, wr_txd, rd_rx, rx_push, tx_req, tx_ack;
  frame_cfg_t cfg;

  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_txd  = bus_wr && bus_addr == A_TXD;
  assign rd_stat = bus_rd && bus_addr == A_STAT;
  assign rd_rx   = bus_rd && bus_addr == A_RXD;
  assign rx_push = rx_valid && ctrl_q[CT_RE];
  assign tx_req  = !stat[ST_TXE] && ctrl_q[CT_TE];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      rate_q  <= '0;
      ctrl_q  <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_MODE:  mode_q <= bus_wdata;
          A_RATE:  rate_q <= bus_wdata;
          A_CTRL:  ctrl_q <= bus_wdata;
          A_TXD:   txd_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (rx_push && !stat[ST_RXF]) rxd_q <= rx_byte;
      if (bus_rd) begin
        case (bus_addr)
          A_MODE:  rdata_q <= mode_q;
          A_RATE:  rdata_q <= rate_q;
          A_CTRL:  rdata_q <= ctrl_q;
          A_TXD:   rdata_q <= txd_q;
          A_STAT:  rdata_q <= stat;
          A_RXD:   rdata_q <= rxd_q;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  sci_mode_dec u_dec (
    .mode_i (mode_q),
    .cfg_o  (cfg)
  );

  sci_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .rd_stat_i (rd_stat),
    .wr_stat_i (wr_stat),
    .wdata_i   (bus_wdata),
    .wr_txd_i  (wr_txd),
    .rd_rx_i   (rd_rx),
    .rx_push_i (rx_push),
    .tx_ack_i  (tx_ack),
    .te_i      (ctrl_q[CT_TE]),
    .stat_o    (stat)
  );

  sci_tx_shift #(.OVS(OVS)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .cfg_i  (cfg),
    .rate_i (rate_q),
    .data_i (txd_q),
    .req_i  (tx_req),
    .ack_o  (tx_ack),
    .line_o (tx_line)
  );

  assign bus_rdata = rdata_q;
  assign tx_irq    = ctrl_q[CT_TIE] && stat[ST_TXE];

  // R6
  rx_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && stat[ST_RXF] && !rd_rx) |=> $stable(rxd_q));
  // R7
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CT_RE]) |=> $stable(rxd_q));
endmodule

// File: tb/sci_core_tb_top.sv
`timescale 1ns/1ps
module sci_core_tb_top;
  localparam int OVS_TB = 4;
  localparam int NV = 7;
  // {mode, rate, data, bit period in cycles}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'hA5, 8'd4},
    {8'h40, 8'h01, 8'hC3, 8'd8},
    {8'h20, 8'h00, 8'h07, 8'd4},
    {8'h30, 8'h00, 8'h07, 8'd4},
    {8'h61, 8'h00, 8'h55, 8'd16},
    {8'h38, 8'h02, 8'h00, 8'd12},
    {8'h02, 8'h00, 8'h81, 8'd64}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_line, tx_irq;
  int checks = 0, failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sci_core #(.OVS(OVS_TB)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_line(tx_line), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_fall(output int t, output bit ok);
    logic prev;
    prev = tx_line;
    ok = 0;
    t = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (prev && !tx_line) begin
        t = cyc; ok = 1; break;
      end
      prev = tx_line;
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] m, input logic [7:0] d);
    int nb;
    logic p;
    logic [11:0] f;
    nb = m[6] ? 7 : 8;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) f[1+i] = d[i];
    p = m[6] ? ^d[6:0] : ^d;
    if (m[5]) f[1+nb] = p ^ m[4];
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [11:0] got;
    int t0, t1, bc;
    bit ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 line idle", tx_line, 1);
    check("R1 irq low", tx_irq, 0);
    rd(3'd4, r); check("R1 status reset", r, 8'h84);

    // R2 register readback
    wr(3'd1, 8'h3C); rd(3'd1, r); check("R2 rate readback", r, 8'h3C);
    wr(3'd1, 8'h00);

    // R4 write 0 without read keeps flag; R5 rx byte
    wr(3'd2, 8'h10);
    push(8'h5A);
    wr(3'd4, 8'h00);
    rd(3'd4, r); check("R4 unread flag kept", r, 8'hC4);
    wr(3'd4, 8'h00);
    rd(3'd4, r); check("R4 read flag cleared", r, 8'h84);
    rd(3'd5, r); check("R5 rx data", r, 8'h5A);

    // R3 software bit, no set by write
    wr(3'd4, 8'hFF);
    rd(3'd4, r); check("R3 write ones sets only sw bit", r, 8'h85);
    wr(3'd4, 8'h00);
    rd(3'd4, r); check("R3 sw bit cleared", r, 8'h84);

    // R5 full then cleared by data read
    push(8'h66);
    rd(3'd4, r); check("R5 rx full", r, 8'hC4);
    rd(3'd5, r); check("R5 rx data 2", r, 8'h66);
    rd(3'd4, r); check("R5 full cleared by read", r, 8'h84);

    // R6 overrun
    push(8'h11);
    push(8'h22);
    rd(3'd4, r); check("R6 overrun flag", r, 8'hE4);
    rd(3'd5, r); check("R6 first byte kept", r, 8'h11);
    rd(3'd4, r); check("R6 overrun persists", r, 8'hA4);
    wr(3'd4, 8'hDE);
    rd(3'd4, r); check("R6 R4 overrun cleared", r, 8'h84);

    // R7 receive disabled
    wr(3'd2, 8'h00);
    push(8'h33);
    rd(3'd4, r); check("R7 no rx full", r, 8'h84);
    rd(3'd5, r); check("R7 rx data unchanged", r, 8'h11);

    // R9 transmit disabled holds flags
    rd(3'd4, r);
    wr(3'd4, 8'h00);
    rd(3'd4, r); check("R9 tx flags held", r, 8'h84);
    check("R9 line idle", tx_line, 1);

    // R8 transmit sequencing
    wr(3'd2, 8'h20);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h99);
    rd(3'd4, r); check("R8 tx end cleared by data write", r, 8'h80);
    wr(3'd4, 8'h78);
    wait_fall(t0, ok); check("R8 transmission started", ok, 1);
    rd(3'd4, r); check("R8 flags set at handoff", r, 8'h84);
    repeat (60) @(negedge clk);

    // R13 interrupt
    wr(3'd2, 8'hA0); check("R13 irq on", tx_irq, 1);
    wr(3'd2, 8'h20); check("R13 irq off", tx_irq, 0);

    // R10 R11 frame table
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VEC[v][31:24]);
      wr(3'd1, VEC[v][23:16]);
      wr(3'd3, VEC[v][15:8]);
      rd(3'd4, r);
      wr(3'd4, 8'h78);
      bc = int'(VEC[v][7:0]);
      wait_fall(t0, ok);
      check("R10 frame start", ok, 1);
      repeat (bc / 2) @(negedge clk);
      got = '1;
      for (int s = 0; s < 12; s++) begin
        got[s] = tx_line;
        if (s < 11) repeat (bc) @(negedge clk);
      end
      check("R10 R11 frame bits", got, exp_frame(VEC[v][31:24], VEC[v][15:8]));
      repeat (2 * bc) @(negedge clk);
    end

    // R12 back-to-back with two stop bits, R13 irq low while queued
    wr(3'd2, 8'hA0);
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd4, r);
    wr(3'd4, 8'h78);
    wait_fall(t0, ok);
    wr(3'd3, 8'h00);
    rd(3'd4, r);
    wr(3'd4, 8'h78);
    rd(3'd4, r); check("R12 second byte queued", r[7], 0);
    check("R13 irq low when queued", tx_irq, 0);
    wait_fall(t1, ok);
    check("R12 start spacing", t1 - t0, 11 * 4 + 1);
    repeat (60) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule